// File: doc/BRIEF.md
# Dual-Channel Converter Code Register Front End

This block sits between a host data bus and a pair of 12-bit converter cores. The bus can be 12 bits wide, or 8 bits wide with the lower nibble sent as a second write. Each channel has two register stages. A channel-select input and a strobe pair fill the first stage of the addressed channel. A second strobe pair copies both first-stage registers into the second stage at the same moment, so both outputs change together.

A second write strobe gates a clear command, which loads the midscale (zero-output) code. When the transfer path is held open, the clear works as a temporary override: the previous codes come back as soon as it is released. All control inputs are active low and level sensitive. They pass through a two-flop synchronizer together with the data, and each register counts as open on every clock cycle in which its enable condition holds. When the strobes are tied low, both stages can run as semi-transparent or fully transparent paths.

Each channel presents its code in three forms:
- the plain offset-binary code;
- a 7-line thermometer of the top three bits, together with the remaining nine bits;
- a two's-complement equivalent of the code.

Top module: `dual_dac_frontend`

## Requirements
- R1: `ch_sel` = 0 addresses channel 1 and `ch_sel` = 1 addresses channel 2. A write never alters the other channel's staging register.
- R2: A staging register changes only in cycles where `cs_n` and `wr_n` are both low. If either one is high, both staging registers hold.
- R3: With `wide_mode` = 1, a write stores all 12 bits of `din` into the addressed staging register.
- R4: With `wide_mode` = 0, a write replaces only bits [3:0] of the addressed staging register, taking them from `din[11:8]`. Bits [11:4] keep their value.
- R5: While `upd_n` and `xfer_n` are both low, both output registers copy their staging registers in the same cycle.
- R6: When neither transfer nor clear is active, the output registers hold their values.
- R7: While `upd_n` and `clr_n` are low and `xfer_n` is high, both output registers are loaded with 12'h800.
- R8: While `upd_n`, `xfer_n` and `clr_n` are all low, both code outputs read 12'h800. Once `clr_n` returns high, with transfer still active, the codes follow the staging registers again.
- R9: Reset sets both staging registers and both output registers to 12'h800.
- R10: `therm_chN[i]` is 1 exactly when `code_chN[11:9]` > i, for i = 0 to 6. `low_chN` equals `code_chN[8:0]`.
- R11: `sval_chN` equals `code_chN` with bit 11 inverted, read as a signed value. So 12'h800 gives 0 and 12'hFFF gives +2047.
- R12: Input changes appear on the outputs at the third rising clock edge after they are applied. With all four strobes held low, bus data reaches the addressed channel's code with that same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ch_sel | input | 1 | Channel address (0 = channel 1, 1 = channel 2) |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Staging write strobe, active low |
| wide_mode | input | 1 | 1 = 12-bit bus, 0 = low-nibble byte write |
| upd_n | input | 1 | Second write strobe, gates transfer and clear |
| xfer_n | input | 1 | Transfer command, active low |
| clr_n | input | 1 | Midscale clear, active low |
| din | input | 12 | Data bus |
| code_ch1 | output | 12 | Channel 1 offset-binary code |
| code_ch2 | output | 12 | Channel 2 offset-binary code |
| therm_ch1 | output | 7 | Channel 1 thermometer of top 3 bits |
| therm_ch2 | output | 7 | Channel 2 thermometer of top 3 bits |
| low_ch1 | output | 9 | Channel 1 lower 9 bits |
| low_ch2 | output | 9 | Channel 2 lower 9 bits |
| sval_ch1 | output | 12 | Channel 1 signed code |
| sval_ch2 | output | 12 | Channel 2 signed code |

## Verification
The bench checks the byte-mode nibble write from the upper data lines. A design that took the nibble from `din[3:0]`, or that also overwrote bits [11:4], would show the wrong code after the next transfer. It releases a temporary clear while the transfer is held open. A design that latched 12'h800 into the output register would then keep reading midscale instead of returning to the staged code. It measures the path latency edge by edge in fully transparent operation and, using random strobe mixes, catches any write that leaks into the unaddressed channel or any transfer that moves only one channel.

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend #(
  parameter int W    = 12,
  parameter int TOPB = 3,
  parameter int SYNC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ch_sel,
  input  logic                    cs_n,
  input  logic                    wr_n,
  input  logic                    wide_mode,
  input  logic                    upd_n,
  input  logic                    xfer_n,
  input  logic                    clr_n,
  input  logic [W-1:0]            din,
  output logic [W-1:0]            code_ch1,
  output logic [W-1:0]            code_ch2,
  output logic [(1<<TOPB)-2:0]    therm_ch1,
  output logic [(1<<TOPB)-2:0]    therm_ch2,
  output logic [W-TOPB-1:0]       low_ch1,
  output logic [W-TOPB-1:0]       low_ch2,
  output logic signed [W-1:0]     sval_ch1,
  output logic signed [W-1:0]     sval_ch2
);
  localparam int THW = (1 << TOPB) - 1;
  localparam int NIB = W - 8;
  localparam int IW  = W + 7;
  localparam logic [W-1:0]  MID  = {1'b1, {(W-1){1'b0}}};
  localparam logic [IW-1:0] IDLE = {2'b00, 5'b11111, {W{1'b0}}};

  logic [IW-1:0] sync_q [SYNC];
  logic          s_a, s_wide, s_cs_n, s_wr_n, s_upd_n, s_xfer_n, s_clr_n;
  logic [W-1:0]  s_d;
  logic          load, xfer, clr, force_q;
  logic [W-1:0]  in_q   [2];
  logic [W-1:0]  in_nxt [2];
  logic [W-1:0]  dac_q  [2];
  logic [W-1:0]  code   [2];
  logic [THW-1:0] therm [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC; k++) sync_q[k] <= IDLE;
    end else begin
      sync_q[0] <= {ch_sel, wide_mode, cs_n, wr_n, upd_n, xfer_n, clr_n, din};
      for (int k = 1; k < SYNC; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  assign {s_a, s_wide, s_cs_n, s_wr_n, s_upd_n, s_xfer_n, s_clr_n, s_d} = sync_q[SYNC-1];
  assign load = !s_cs_n && !s_wr_n;
  assign xfer = !s_upd_n && !s_xfer_n;
  assign clr  = !s_upd_n && !s_clr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_q <= 1'b0;
    else        force_q <= xfer && clr;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    always_comb begin
      in_nxt[ch] = in_q[ch];
      if (load && (s_a == ch[0])) begin
        if (s_wide) in_nxt[ch] = s_d;
        else        in_nxt[ch][NIB-1:0] = s_d[W-1 -: NIB];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q[ch]  <= MID;
        dac_q[ch] <= MID;
      end else begin
        in_q[ch] <= in_nxt[ch];
        if (xfer)     dac_q[ch] <= in_nxt[ch];
        else if (clr) dac_q[ch] <= MID;
      end
    end

    assign code[ch] = force_q ? MID : dac_q[ch];

    for (genvar i = 0; i < THW; i++) begin : g_th
      assign therm[ch][i] = (code[ch][W-1 -: TOPB] > i[TOPB-1:0]);
    end
  end

  assign code_ch1  = code[0];
  assign code_ch2  = code[1];
  assign therm_ch1 = therm[0];
  assign therm_ch2 = therm[1];
  assign low_ch1   = code[0][W-TOPB-1:0];
  assign low_ch2   = code[1][W-TOPB-1:0];
  assign sval_ch1  = {~code[0][W-1], code[0][W-2:0]};
  assign sval_ch2  = {~code[1][W-1], code[1][W-2:0]};
endmodule

// File: rtl/dual_dac_frontend_chk.sv
module dual_dac_frontend_chk #(
  parameter int W = 12,
  parameter int THW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           s_a,
  input logic           s_wide,
  input logic           s_cs_n,
  input logic           s_wr_n,
  input logic           s_upd_n,
  input logic           s_xfer_n,
  input logic           s_clr_n,
  input logic [W-1:0]   in1,
  input logic [W-1:0]   in2,
  input logic [W-1:0]   dac1,
  input logic [W-1:0]   dac2,
  input logic [W-1:0]   code1,
  input logic [W-1:0]   code2,
  input logic [THW-1:0] th1,
  input logic [THW-1:0] th2
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  p_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cs_n || s_wr_n) |=> ($stable(in1) && $stable(in2)));

  p_other_ch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_a) |=> $stable(in2));

  p_byte_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_wide && !s_a) |=> (in1[W-1:W-8] == $past(in1[W-1:W-8])));

  p_dac_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_upd_n || (s_xfer_n && s_clr_n)) |=> ($stable(dac1) && $stable(dac2)));

  p_clear_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_upd_n && !s_clr_n && s_xfer_n) |=> (dac1 == MID && dac2 == MID));

  p_force_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_upd_n && !s_clr_n && !s_xfer_n) |=> (code1 == MID && code2 == MID));

  p_therm_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((th1 & (th1 + 1'b1)) == '0) && ((th2 & (th2 + 1'b1)) == '0));
endmodule

bind dual_dac_frontend dual_dac_frontend_chk #(.W(W), .THW((1 << TOPB) - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_a(s_a), .s_wide(s_wide), .s_cs_n(s_cs_n),
  .s_wr_n(s_wr_n), .s_upd_n(s_upd_n), .s_xfer_n(s_xfer_n), .s_clr_n(s_clr_n),
  .in1(in_q[0]), .in2(in_q[1]), .dac1(dac_q[0]), .dac2(dac_q[1]),
  .code1(code_ch1), .code2(code_ch2), .th1(therm_ch1), .th2(therm_ch2)
);

// File: tb/dual_dac_frontend_bench.sv
module dual_dac_frontend_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ch_sel = 0, cs_n = 1, wr_n = 1, wide_mode = 1, upd_n = 1, xfer_n = 1, clr_n = 1;
  logic [11:0] din = '0;
  logic [11:0] code_ch1, code_ch2, sval_ch1, sval_ch2;
  logic [6:0]  therm_ch1, therm_ch2;
  logic [8:0]  low_ch1, low_ch2;
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [11:0] in1m = 12'h800, in2m = 12'h800, d1m = 12'h800, d2m = 12'h800;
  logic forcem = 1'b0;

  always #5ns clk = ~clk;

  dual_dac_frontend u_dual_dac_frontend (
    .clk(clk), .rst_n(rst_n), .ch_sel(ch_sel), .cs_n(cs_n), .wr_n(wr_n),
    .wide_mode(wide_mode), .upd_n(upd_n), .xfer_n(xfer_n), .clr_n(clr_n), .din(din),
    .code_ch1(code_ch1), .code_ch2(code_ch2), .therm_ch1(therm_ch1), .therm_ch2(therm_ch2),
    .low_ch1(low_ch1), .low_ch2(low_ch2), .sval_ch1(sval_ch1), .sval_ch2(sval_ch2));

  function automatic logic [6:0] therm_of(logic [11:0] c);
    for (int i = 0; i < 7; i++) therm_of[i] = (c[11:9] > i);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [11:0] e1, e2;
    e1 = forcem ? 12'h800 : d1m;
    e2 = forcem ? 12'h800 : d2m;
    chk(tag, code_ch1, e1);
    chk(tag, code_ch2, e2);
    chk("R10 therm", therm_ch1, therm_of(e1));
    chk("R10 therm", therm_ch2, therm_of(e2));
    chk("R10 low", low_ch1, e1[8:0]);
    chk("R10 low", low_ch2, e2[8:0]);
    chk("R11 signed", sval_ch1, {~e1[11], e1[10:0]});
    chk("R11 signed", sval_ch2, {~e2[11], e2[10:0]});
  endtask

  task automatic apply(logic a, logic cs, logic wr, logic wide, logic up,
                       logic xf, logic cl, logic [11:0] d);
    logic [11:0] n1, n2;
    ch_sel = a; cs_n = cs; wr_n = wr; wide_mode = wide;
    upd_n = up; xfer_n = xf; clr_n = cl; din = d;
    n1 = in1m; n2 = in2m;
    if (!cs && !wr) begin
      if (!a) n1 = wide ? d : {in1m[11:4], d[11:8]};
      else    n2 = wide ? d : {in2m[11:4], d[11:8]};
    end
    if (!up && !xf) begin d1m = n1; d2m = n2; end
    else if (!up && !cl) begin d1m = 12'h800; d2m = 12'h800; end
    in1m = n1; in2m = n2;
    forcem = !up && !xf && !cl;
  endtask

  task automatic op(string tag, logic a, logic cs, logic wr, logic wide, logic up,
                    logic xf, logic cl, logic [11:0] d);
    apply(a, cs, wr, wide, up, xf, cl, d);
    repeat (4) @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(string tag);
    op(tag, ch_sel, 1, 1, 1, 1, 1, 1, din);
  endtask

  initial begin
    logic [11:0] old;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R9 reset");
    op("R3 wide write ch1", 0, 0, 0, 1, 1, 1, 1, 12'hABC);
    idle("R6 staged only");
    op("R5 transfer", 0, 1, 1, 1, 0, 0, 1, 12'h000);
    idle("R5");
    op("R1 write ch2", 1, 0, 0, 1, 1, 1, 1, 12'h123);
    op("R2 cs only", 1, 0, 1, 1, 1, 1, 1, 12'hFFF);
    op("R2 wr only", 0, 1, 0, 1, 1, 1, 1, 12'hEEE);
    op("R5 transfer both", 0, 1, 1, 1, 0, 0, 1, 12'h000);
    idle("R1");
    op("R3 msb byte", 0, 0, 0, 1, 1, 1, 1, 12'h56F);
    op("R4 low nibble", 0, 0, 0, 0, 1, 1, 1, 12'h9AB);
    idle("R4");
    op("R4 transfer", 0, 1, 1, 1, 0, 0, 1, 12'h000);
    op("R6 upd without cmd", 0, 1, 1, 1, 0, 1, 1, 12'h000);
    op("R7 clear", 0, 1, 1, 1, 0, 1, 0, 12'h000);
    idle("R7");
    op("R8 force", 0, 1, 1, 1, 0, 0, 0, 12'h000);
    op("R8 release", 0, 1, 1, 1, 0, 0, 1, 12'h000);
    idle("R8");
    old = d2m;
    apply(1, 0, 0, 1, 0, 0, 1, 12'h7E5);
    repeat (2) @(negedge clk);
    chk("R12 before third edge", code_ch2, old);
    @(negedge clk);
    chk("R12 at third edge", code_ch2, 12'h7E5);
    @(negedge clk);
    check_all("R12 transparent");
    op("R12 transparent ch1", 0, 0, 0, 1, 0, 0, 1, 12'h0FF);
    idle("R12");
    for (int n = 0; n < 300; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      op("R5 random", r[0], ($urandom % 3) == 0 ? 1'b1 : r[1], r[2], r[3],
         r[4], r[5] | r[6], r[7] | r[5], 12'($urandom));
    end
    op("R11 full scale", 0, 0, 0, 1, 0, 0, 1, 12'hFFF);
    op("R11 zero scale", 1, 0, 0, 1, 0, 0, 1, 12'h000);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule